// File: doc/BRIEF.md
# Chained FIFO Segment Token Controller

This block controls a deep FIFO built from several equal memory segments joined in a ring. Two tokens travel around the ring: one marks the segment that takes the next stored word, the other marks the segment that gives up the next word to be read. A segment serves a shared store or take strobe only while it holds the matching token. Every other segment ignores it.

When the owning segment stores into its highest location, it raises a one-cycle handoff pulse toward its ring neighbour, and the next word goes to address zero of that neighbour. Takes move around the ring in the same way on a separate pulse. The last segment's pulses wrap back to the first.

An active-low start-select input, one bit per segment, names the segment that holds both tokens after reset. The memory arrays are not part of the block; each segment is modelled by its store and take pointers and an occupancy count. The block combines the per-segment active-low full and empty flags into chain-wide flags. Replay of stored data and a half-level flag are not offered in this chained arrangement.

Top module: `dxr_chain`

## Requirements
- R1: While `rstN` is low, exactly one bit of `firstLoadN` is low, at index F. After reset, all pointers read zero, `emptyN` is 0 and `fullN` is 1. The first store and the first take both go to segment F.
- R2: A store request lands only in the segment holding the store token, at that segment's store pointer. `segWrStore` is one-hot on a store and zero otherwise. Every other segment's store pointer stays 0.
- R3: A take request is served only by the segment holding the take token, at that segment's take pointer. `segRdTake` is one-hot on a take and zero otherwise. Every other segment's take pointer stays 0.
- R4: A store at address SEG_DEPTH-1 of segment s raises `xoWr[s]` in that same cycle only. The next store goes to address 0 of segment (s+1) mod NUM_SEG, so segment NUM_SEG-1 hands off to segment 0.
- R5: A take at address SEG_DEPTH-1 of segment s raises `xoRd[s]` in that same cycle only. The next take comes from address 0 of segment (s+1) mod NUM_SEG.
- R6: `emptyN` is low exactly when every segment is empty, which means the chain holds no words. While it is low, take requests are ignored.
- R7: `fullN` is low exactly when every segment is full, which means the chain holds NUM_SEG*SEG_DEPTH words. While it is low, store requests are ignored.
- R8: A store and a take requested in the same cycle are both performed when the chain is neither full nor empty. When the chain is full only the take is done, and when it is empty only the store is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| firstLoadN | input | NUM_SEG | Active-low start-select, one bit per segment |
| wrReq | input | 1 | Shared store request |
| rdReq | input | 1 | Shared take request |
| segWrStore | output | NUM_SEG | Per-segment store strobe |
| segRdTake | output | NUM_SEG | Per-segment take strobe |
| xoWr | output | NUM_SEG | Per-segment store handoff pulse |
| xoRd | output | NUM_SEG | Per-segment take handoff pulse |
| segWrPtr | output | NUM_SEG*PTR_W | Store pointers, segment s in bits [s*PTR_W +: PTR_W] |
| segRdPtr | output | NUM_SEG*PTR_W | Take pointers, same packing |
| fullN | output | 1 | Chain-wide full, active low |
| emptyN | output | 1 | Chain-wide empty, active low |

## Verification
The token one-hot and handoff properties assume that `firstLoadN` has exactly one low bit while reset is asserted. The bench keeps to this by resetting with a single low bit, once at each index. Requests are assumed to be driven only between clock edges. The bench changes `wrReq` and `rdReq` only on falling edges, and it deliberately issues stores into a full chain and takes from an empty chain, because the block has to absorb both.

// File: rtl/dxr_pkg.sv
`timescale 1ns/1ps
package dxr_pkg;
  // Strobes from a segment's control to its pointer datapath.
  typedef struct packed {
    logic wrStore;
    logic rdTake;
  } segStrobe_t;
endpackage

// File: rtl/dxr_seg_ctrl.sv
`timescale 1ns/1ps
module dxr_seg_ctrl
  import dxr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       firstLoadN,
  input  logic       wrReq,
  input  logic       rdReq,
  input  logic       xiWr,
  input  logic       xiRd,
  input  logic       segFullN,
  input  logic       segEmptyN,
  input  logic       atWrLast,
  input  logic       atRdLast,
  output segStrobe_t strobe,
  output logic       xoWr,
  output logic       xoRd,
  output logic       wrTok,
  output logic       rdTok
);
  always_comb begin
    strobe.wrStore = wrReq & wrTok & segFullN;
    strobe.rdTake  = rdReq & rdTok & segEmptyN;
    xoWr = strobe.wrStore & atWrLast;
    xoRd = strobe.rdTake & atRdLast;
  end

  // An incoming pulse wins over an outgoing one, so a one-segment ring keeps its token.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTok <= ~firstLoadN;
      rdTok <= ~firstLoadN;
    end else begin
      if (xiWr)      wrTok <= 1'b1;
      else if (xoWr) wrTok <= 1'b0;
      if (xiRd)      rdTok <= 1'b1;
      else if (xoRd) rdTok <= 1'b0;
    end
  end

  // R7
  wr_needs_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    !segFullN |-> !strobe.wrStore);
endmodule

// File: rtl/dxr_seg_ptrs.sv
`timescale 1ns/1ps
module dxr_seg_ptrs
  import dxr_pkg::*;
#(
  parameter int SEG_DEPTH = 4,
  parameter int PTR_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  segStrobe_t       strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             atWrLast,
  output logic             atRdLast,
  output logic             segFullN,
  output logic             segEmptyN
);
  localparam logic [PTR_W-1:0] LAST_ADDR = PTR_W'(SEG_DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP       = CNT_W'(SEG_DEPTH);

  logic [CNT_W-1:0] occ;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    atWrLast  = (wrPtr == LAST_ADDR);
    atRdLast  = (rdPtr == LAST_ADDR);
    segFullN  = (occ != CAP);
    segEmptyN = (occ != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobe.wrStore) wrPtr <= stepPtr(wrPtr);
      if (strobe.rdTake)  rdPtr <= stepPtr(rdPtr);
      if (strobe.wrStore && !strobe.rdTake)      occ <= occ + 1'b1;
      else if (!strobe.wrStore && strobe.rdTake) occ <= occ - 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CAP);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdTake |-> occ != '0);
  // R4
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStore && atWrLast) |=> wrPtr == '0);
  // R5
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdTake && atRdLast) |=> rdPtr == '0);
endmodule

// File: rtl/dxr_chain.sv
`timescale 1ns/1ps
module dxr_chain
  import dxr_pkg::*;
#(
  parameter int NUM_SEG   = 3,
  parameter int SEG_DEPTH = 4,
  localparam int PTR_W    = (SEG_DEPTH > 1) ? $clog2(SEG_DEPTH) : 1,
  localparam int CNT_W    = $clog2(SEG_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SEG-1:0]       firstLoadN,
  input  logic                     wrReq,
  input  logic                     rdReq,
  output logic [NUM_SEG-1:0]       segWrStore,
  output logic [NUM_SEG-1:0]       segRdTake,
  output logic [NUM_SEG-1:0]       xoWr,
  output logic [NUM_SEG-1:0]       xoRd,
  output logic [NUM_SEG*PTR_W-1:0] segWrPtr,
  output logic [NUM_SEG*PTR_W-1:0] segRdPtr,
  output logic                     fullN,
  output logic                     emptyN
);
  logic [NUM_SEG-1:0] wrTokV, rdTokV, segFullV, segEmptyV;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    localparam int PREV = (g == 0) ? NUM_SEG - 1 : g - 1;
    localparam int NEXT = (g == NUM_SEG - 1) ? 0 : g + 1;

    segStrobe_t strobe;
    logic atWrLast, atRdLast;

    dxr_seg_ctrl ctrl_i (
      .clk        (clk),
      .rstN       (rstN),
      .firstLoadN (firstLoadN[g]),
      .wrReq      (wrReq),
      .rdReq      (rdReq),
      .xiWr       (xoWr[PREV]),
      .xiRd       (xoRd[PREV]),
      .segFullN   (segFullV[g]),
      .segEmptyN  (segEmptyV[g]),
      .atWrLast   (atWrLast),
      .atRdLast   (atRdLast),
      .strobe     (strobe),
      .xoWr       (xoWr[g]),
      .xoRd       (xoRd[g]),
      .wrTok      (wrTokV[g]),
      .rdTok      (rdTokV[g])
    );

    dxr_seg_ptrs #(.SEG_DEPTH(SEG_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) ptrs_i (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobe),
      .wrPtr     (segWrPtr[g*PTR_W +: PTR_W]),
      .rdPtr     (segRdPtr[g*PTR_W +: PTR_W]),
      .atWrLast  (atWrLast),
      .atRdLast  (atRdLast),
      .segFullN  (segFullV[g]),
      .segEmptyN (segEmptyV[g])
    );

    assign segWrStore[g] = strobe.wrStore;
    assign segRdTake[g]  = strobe.rdTake;

    // R4
    wr_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
      xoWr[g] |=> wrTokV[NEXT]);
    // R5
    rd_handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
      xoRd[g] |=> rdTokV[NEXT]);
    if (SEG_DEPTH > 1) begin : gPulse
      // R4
      wr_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
        xoWr[g] |=> !xoWr[g]);
      // R5
      rd_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
        xoRd[g] |=> !xoRd[g]);
    end
  end

  // Active-low flags: the chain flag is low only when every segment's is low.
  assign fullN  = |segFullV;
  assign emptyN = |segEmptyV;

  // R1
  first_sel_chk: assert property (@(posedge clk)
    !rstN |-> $onehot(~firstLoadN));
  // R1
  reset_tok_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (wrTokV == ~firstLoadN) && (rdTokV == ~firstLoadN));
  // R2
  wr_tok_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wrTokV));
  // R3
  rd_tok_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdTokV));
  // R7
  full_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> segWrStore == '0);
  // R6
  empty_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !emptyN |-> segRdTake == '0);
  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(segWrStore));
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(segRdTake));
endmodule

// File: tb/dxr_chain_tb_top.sv
`timescale 1ns/1ps
module dxr_chain_tb_top;
  localparam int N   = 3;
  localparam int D   = 4;
  localparam int PW  = 2;
  localparam int TOT = N * D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] firstLoadN = 3'b110;
  logic wrReq = 1'b0;
  logic rdReq = 1'b0;
  logic [N-1:0] segWrStore, segRdTake, xoWr, xoRd;
  logic [N*PW-1:0] segWrPtr, segRdPtr;
  logic fullN, emptyN;

  int nChecks = 0;
  int nFail = 0;
  int first = 0;
  int w = 0;
  int r = 0;

  always #10 clk = ~clk;

  dxr_chain #(.NUM_SEG(N), .SEG_DEPTH(D)) dut_i (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrReq(wrReq), .rdReq(rdReq),
    .segWrStore(segWrStore), .segRdTake(segRdTake),
    .xoWr(xoWr), .xoRd(xoRd),
    .segWrPtr(segWrPtr), .segRdPtr(segRdPtr),
    .fullN(fullN), .emptyN(emptyN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  task automatic doReset(input int f);
    @(negedge clk);
    rstN = 1'b0;
    wrReq = 1'b0;
    rdReq = 1'b0;
    firstLoadN = ~(N'(1) << f);
    first = f;
    w = 0;
    r = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(segWrPtr == '0, "R1 store pointers", int'(segWrPtr), 0);
    chk(segRdPtr == '0, "R1 take pointers", int'(segRdPtr), 0);
    chk(emptyN == 1'b0, "R1 emptyN", int'(emptyN), 0);
    chk(fullN == 1'b1, "R1 fullN", int'(fullN), 1);
  endtask

  task automatic step(input bit wr, input bit rd);
    int occ, wseg, rseg, expWs, expRt, expXw, expXr;
    bit doWr, doRd;
    @(negedge clk);
    wrReq = wr;
    rdReq = rd;
    #1;
    occ  = w - r;
    wseg = (first + (w / D)) % N;
    rseg = (first + (r / D)) % N;
    doWr = wr && (occ < TOT);
    doRd = rd && (occ > 0);
    expWs = doWr ? (1 << wseg) : 0;
    expRt = doRd ? (1 << rseg) : 0;
    expXw = (doWr && (w % D == D - 1)) ? (1 << wseg) : 0;
    expXr = (doRd && (r % D == D - 1)) ? (1 << rseg) : 0;
    chk(int'(segWrStore) == expWs, (occ == TOT) ? "R7 store blocked" : "R2 store strobe",
        int'(segWrStore), expWs);
    chk(int'(segRdTake) == expRt, (occ == 0) ? "R6 take blocked" : "R3 take strobe",
        int'(segRdTake), expRt);
    chk(int'(xoWr) == expXw, "R4 store handoff pulse", int'(xoWr), expXw);
    chk(int'(xoRd) == expXr, "R5 take handoff pulse", int'(xoRd), expXr);
    chk(fullN == (occ != TOT), "R7 fullN", int'(fullN), int'(occ != TOT));
    chk(emptyN == (occ != 0), "R6 emptyN", int'(emptyN), int'(occ != 0));
    if (wr && rd && occ > 0 && occ < TOT)
      chk(segWrStore != '0 && segRdTake != '0, "R8 both performed",
          int'(segWrStore != '0) + int'(segRdTake != '0), 2);
    for (int s = 0; s < N; s++) begin
      int expWp, expRp;
      expWp = (s == wseg) ? (w % D) : 0;
      expRp = (s == rseg) ? (r % D) : 0;
      chk(int'(segWrPtr[s*PW +: PW]) == expWp, "R2 store pointer",
          int'(segWrPtr[s*PW +: PW]), expWp);
      chk(int'(segRdPtr[s*PW +: PW]) == expRp, "R3 take pointer",
          int'(segRdPtr[s*PW +: PW]), expRp);
    end
    @(posedge clk);
    if (doWr) w++;
    if (doRd) r++;
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int f = 0; f < N; f++) begin
      doReset(f);
      step(1'b0, 1'b0);
      // R7: fill past capacity
      for (int k = 0; k < TOT + 2; k++) step(1'b1, 1'b0);
      // R8: both requested while full
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      // R6: drain past empty
      for (int k = 0; k < TOT + 2; k++) step(1'b0, 1'b1);
      // R8: both requested while empty
      step(1'b1, 1'b1);
      // Mixed patterns with ring wraps of both tokens
      for (int k = 0; k < 60; k++) step(k % 3 != 0, k % 4 != 0);
      for (int k = 0; k < 40; k++) step(1'b1, k % 3 == 0);
      for (int k = 0; k < 50; k++) step(k % 4 == 0, 1'b1);
      for (int k = 0; k < 60; k++) step(1'b1, 1'b1);
    end
    summary();
  end
endmodule